// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the sequencing engine of one DMA channel. A transfer is described by a four-word descriptor: a device address, a memory address, a size word and a link word. Software places the first descriptor on the configuration inputs and pulses start. The engine then moves data one element at a time. Each element is a read handshake from the source followed by a write handshake to the destination. The memory-side address steps by the element size after every element, while the device-side address stays fixed, as for a peripheral FIFO register.

The size word carries both the element count and the element width. The two low bits of the link word say whether the descriptor is the last one and whether its completion raises an interrupt. In scatter-gather mode the engine follows the link. It reads the next descriptor as four words from memory through a simple read port and then runs it. In one-shot mode only the loaded descriptor runs. Disabling the channel stops it at the next element boundary.

Top module: `dmac_chain_engine`

## Requirements
- R1: Size word bits [13:12] select the element width: 3 = 1 byte, 2 = 2 bytes, 0 = 4 bytes. `elem_sz_o` reports log2 of the byte count. The memory address advances by the element size after each element. The device address never changes within a descriptor.
- R2: A size word with width code 1, or with a count (bits [11:0]) above its limit, is rejected. The limit is 0x3FF for 1-byte and 2-byte widths and 0x7FF for 4-byte width. A rejected word gives a one-cycle `err_o` pulse and no data request, and the channel returns to idle. A count equal to its limit is accepted.
- R3: With `dir_i` = 1 each element is read from the memory address and written to the device address. With `dir_i` = 0 it is read from the device address and written to the memory address. The written data equals the data read for that element.
- R4: With `mode_i` = 2 (one-shot) only the loaded descriptor runs, even when its link code asks to follow.
- R5: With `mode_i` = 1 (scatter-gather), a link code with bit 1 set makes the engine fetch the next descriptor. It reads four words at the link address with bits [1:0] cleared, plus 0, 4, 8 and 12, in the order device address, memory address, size, link, and then runs that descriptor.
- R6: A descriptor whose link code has bit 0 set gives a one-cycle `irq_o` pulse in the cycle after its last write handshake. This covers last descriptors (code 1) and linking descriptors (code 3). Codes 0 and 2 give no pulse.
- R7: If `mode_i` is 0 or 3 at an element boundary that is not the last element, the channel returns to idle. It gives no interrupt and makes no further request.
- R8: `state_o` reads 0 when idle, 1 while fetching a descriptor, 2 for the one-cycle check after a descriptor is loaded, and 3 while moving data. It returns to 0 when a chain completes, fails or is aborted.
- R9: `start_i` is ignored while the channel is not idle, and also when `mode_i` is 0 or 3.
- R10: A descriptor with count 0 moves no data. It still completes: its interrupt code and its link are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0/3 disabled, 1 scatter-gather, 2 one-shot |
| dir_i | input | 1 | 1 memory-to-device, 0 device-to-memory; captured at start |
| start_i | input | 1 | Start pulse, taken only when idle |
| cfg_dev_i | input | 32 | First descriptor device address |
| cfg_mem_i | input | 32 | First descriptor memory address |
| cfg_size_i | input | 14 | First descriptor size word (width code and count) |
| cfg_next_i | input | 32 | First descriptor link word |
| dsc_req_o | output | 1 | Descriptor word read request |
| dsc_addr_o | output | 32 | Descriptor word address |
| dsc_ack_i | input | 1 | Descriptor word returned this cycle |
| dsc_data_i | input | 32 | Descriptor word data |
| rd_req_o | output | 1 | Element read request |
| rd_addr_o | output | 32 | Element read address |
| rd_ack_i | input | 1 | Element read completes this cycle |
| rd_data_i | input | 32 | Element read data |
| wr_req_o | output | 1 | Element write request |
| wr_addr_o | output | 32 | Element write address |
| wr_data_o | output | 32 | Element write data |
| wr_ack_i | input | 1 | Element write completes this cycle |
| elem_sz_o | output | 2 | Element size, log2 of bytes |
| state_o | output | 2 | Channel state code |
| irq_o | output | 1 | Descriptor completion interrupt pulse |
| err_o | output | 1 | Bad descriptor pulse |

## Verification
The assertions assume that an acknowledge arrives only while its request is high and lasts a single cycle. They also assume that `mode_i` changes only while a chain runs, when it is meant to abort it. The bench responders raise each acknowledge for one cycle after a programmable delay, and only while the matching request is seen. `mode_i` is lowered only in the abort scenario, just after an element boundary. That lets the check on exactly two moved elements follow from the element timing alone.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CHECK = 2'd2,
    ST_MOVE  = 2'd3
  } dmac_state_e;

  localparam logic [1:0] MODE_SG  = 2'd1;
  localparam logic [1:0] MODE_ONE = 2'd2;

  // bytes per element for a width code, 0 for the illegal code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd3:    return 3'd1;
      2'd2:    return 3'd2;
      2'd0:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] width_log2(input logic [1:0] code);
    case (code)
      2'd3:    return 2'd0;
      2'd2:    return 2'd1;
      2'd0:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] count_limit(input logic [1:0] code);
    case (code)
      2'd0:       return 32'h7FF;
      2'd2, 2'd3: return 32'h3FF;
      default:    return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/dmac_size_decode.sv
module dmac_size_decode
  import dmac_pkg::*;
#(
  parameter int WPOS = 12
) (
  input  logic [WPOS+1:0] size_i,
  output logic            legal_o,
  output logic [WPOS-1:0] count_o,
  output logic [2:0]      step_o,
  output logic [1:0]      lg_o
);
  logic [1:0] wcode;

  always_comb begin
    wcode   = size_i[WPOS+1:WPOS];
    count_o = size_i[WPOS-1:0];
    step_o  = width_bytes(wcode);
    lg_o    = width_log2(wcode);
    legal_o = (wcode != 2'd1) && (32'(count_o) <= count_limit(wcode));
  end
endmodule

// File: rtl/dmac_desc_fetch.sv
module dmac_desc_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic [AW-1:0] base_i,
  output logic          dsc_req_o,
  output logic [AW-1:0] dsc_addr_o,
  input  logic          dsc_ack_i,
  output logic          word_we_o,
  output logic [1:0]    word_idx_o,
  output logic          done_o
);
  logic          busy_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] base_q;

  assign dsc_req_o  = busy_q;
  assign dsc_addr_o = base_q + AW'({idx_q, 2'b00});
  assign word_we_o  = busy_q && dsc_ack_i;
  assign word_idx_o = idx_q;
  assign done_o     = word_we_o && (idx_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= 2'd0;
      base_q <= '0;
    end else if (kick_i) begin
      busy_q <= 1'b1;
      idx_q  <= 2'd0;
      base_q <= base_i;
    end else if (word_we_o) begin
      idx_q <= idx_q + 2'd1;
      if (idx_q == 2'd3) busy_q <= 1'b0;
    end
  end

  AST_DSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req_o && !dsc_ack_i) |=> (dsc_req_o && $stable(dsc_addr_o))); // R5
  AST_DSC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req_o |-> (dsc_addr_o[1:0] == 2'b00)); // R5
endmodule

// File: rtl/dmac_elem_mover.sv
module dmac_elem_mover #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic          done_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

  phase_e        ph_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] data_q;

  assign rd_req_o  = (ph_q == PH_READ);
  assign rd_addr_o = src_q;
  assign wr_req_o  = (ph_q == PH_WRITE);
  assign wr_addr_o = dst_q;
  assign wr_data_o = data_q;
  assign done_o    = wr_req_o && wr_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (en_i) begin
          ph_q  <= PH_READ;
          src_q <= src_i;
          dst_q <= dst_i;
        end
        PH_READ: if (rd_ack_i) begin
          ph_q   <= PH_WRITE;
          data_q <= rd_data_i;
        end
        PH_WRITE: if (wr_ack_i) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R3
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
  import dmac_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int WPOS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            dir_i,
  input  logic            start_i,
  input  logic [AW-1:0]   cfg_dev_i,
  input  logic [AW-1:0]   cfg_mem_i,
  input  logic [WPOS+1:0] cfg_size_i,
  input  logic [AW-1:0]   cfg_next_i,
  output logic            dsc_req_o,
  output logic [AW-1:0]   dsc_addr_o,
  input  logic            dsc_ack_i,
  input  logic [AW-1:0]   dsc_data_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_ack_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  input  logic            wr_ack_i,
  output logic [1:0]      elem_sz_o,
  output logic [1:0]      state_o,
  output logic            irq_o,
  output logic            err_o
);
  localparam int SW = WPOS + 2;

  dmac_state_e   st_q;
  logic [AW-1:0] dev_q, mem_q, next_q;
  logic [SW-1:0] size_q;
  logic          dir_q;
  logic [WPOS-1:0] rem_q;
  logic          irq_q, err_q;

  // decoded descriptor
  logic            dec_legal;
  logic [WPOS-1:0] dec_count;
  logic [2:0]      dec_step;
  logic [1:0]      dec_lg;

  // named internal events
  logic mode_ok, elem_done, desc_end, link_go, abort_now, bad_desc;
  logic fetch_we, fetch_done;
  logic [1:0] fetch_idx;

  dmac_size_decode #(.WPOS(WPOS)) u_dec (
    .size_i (size_q),
    .legal_o(dec_legal),
    .count_o(dec_count),
    .step_o (dec_step),
    .lg_o   (dec_lg)
  );

  dmac_desc_fetch #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_i    (link_go),
    .base_i    ({next_q[AW-1:2], 2'b00}),
    .dsc_req_o (dsc_req_o),
    .dsc_addr_o(dsc_addr_o),
    .dsc_ack_i (dsc_ack_i),
    .word_we_o (fetch_we),
    .word_idx_o(fetch_idx),
    .done_o    (fetch_done)
  );

  dmac_elem_mover #(.AW(AW), .DW(DW)) u_mover (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (st_q == ST_MOVE),
    .src_i    (dir_q ? mem_q : dev_q),
    .dst_i    (dir_q ? dev_q : mem_q),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_ack_i (rd_ack_i),
    .rd_data_i(rd_data_i),
    .wr_req_o (wr_req_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .wr_ack_i (wr_ack_i),
    .done_o   (elem_done)
  );

  always_comb begin
    mode_ok   = (mode_i == MODE_SG) || (mode_i == MODE_ONE);
    bad_desc  = (st_q == ST_CHECK) && mode_ok && !dec_legal;
    desc_end  = ((st_q == ST_CHECK) && mode_ok && dec_legal && (dec_count == '0)) ||
                ((st_q == ST_MOVE) && elem_done && (rem_q == WPOS'(1)));
    link_go   = desc_end && next_q[1] && (mode_i == MODE_SG);
    abort_now = ((st_q == ST_CHECK) && !mode_ok) ||
                ((st_q == ST_MOVE) && elem_done && (rem_q != WPOS'(1)) && !mode_ok);
  end

  assign state_o   = st_q;
  assign elem_sz_o = dec_lg;
  assign irq_o     = irq_q;
  assign err_o     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dev_q  <= '0;
      mem_q  <= '0;
      size_q <= '0;
      next_q <= '0;
      dir_q  <= 1'b0;
      rem_q  <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q <= desc_end && next_q[0];
      err_q <= bad_desc;
      case (st_q)
        ST_IDLE: if (start_i && mode_ok) begin
          dev_q  <= cfg_dev_i;
          mem_q  <= cfg_mem_i;
          size_q <= cfg_size_i;
          next_q <= cfg_next_i;
          dir_q  <= dir_i;
          st_q   <= ST_CHECK;
        end
        ST_FETCH: begin
          if (fetch_we) begin
            case (fetch_idx)
              2'd0:    dev_q  <= dsc_data_i;
              2'd1:    mem_q  <= dsc_data_i;
              2'd2:    size_q <= dsc_data_i[SW-1:0];
              default: next_q <= dsc_data_i;
            endcase
          end
          if (fetch_done) st_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (abort_now || bad_desc) st_q <= ST_IDLE;
          else if (desc_end)         st_q <= link_go ? ST_FETCH : ST_IDLE;
          else begin
            rem_q <= dec_count;
            st_q  <= ST_MOVE;
          end
        end
        ST_MOVE: if (elem_done) begin
          mem_q <= mem_q + AW'(dec_step);
          rem_q <= rem_q - WPOS'(1);
          if (desc_end)       st_q <= link_go ? ST_FETCH : ST_IDLE;
          else if (abort_now) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o) && !(dsc_req_o && (rd_req_o || wr_req_o))); // R8
  AST_DATA_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o || wr_req_o) |-> (state_o == 2'd3)); // R8
  AST_DEV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MOVE) && ($past(st_q) == ST_MOVE)) |-> $stable(dev_q)); // R1
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state_o == 2'd0)); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R6
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_end && (mode_i == MODE_ONE)) |=> (state_o == 2'd0)); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> ((state_o == 2'd0) && !irq_o && !rd_req_o)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_MOVE) && start_i && !elem_done) |=> (st_q == ST_MOVE)); // R9
endmodule

// File: tb/dmac_chain_engine_tb.sv
module dmac_chain_engine_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic dir_i = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] cfg_dev_i = '0, cfg_mem_i = '0, cfg_next_i = '0;
  logic [13:0] cfg_size_i = '0;
  logic dsc_req_o, rd_req_o, wr_req_o, irq_o, err_o;
  logic [31:0] dsc_addr_o, rd_addr_o, wr_addr_o, wr_data_o;
  logic dsc_ack_i = 1'b0, rd_ack_i = 1'b0, wr_ack_i = 1'b0;
  logic [31:0] dsc_data_i = '0, rd_data_i = '0;
  logic [1:0] elem_sz_o, state_o;

  always #(CLK_P/2) clk = ~clk;

  dmac_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i), .start_i(start_i),
    .cfg_dev_i(cfg_dev_i), .cfg_mem_i(cfg_mem_i), .cfg_size_i(cfg_size_i),
    .cfg_next_i(cfg_next_i), .dsc_req_o(dsc_req_o), .dsc_addr_o(dsc_addr_o),
    .dsc_ack_i(dsc_ack_i), .dsc_data_i(dsc_data_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ack_i(wr_ack_i), .elem_sz_o(elem_sz_o), .state_o(state_o),
    .irq_o(irq_o), .err_o(err_o)
  );

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0, n_irq = 0, n_dsc = 0;
  int dsc_dly = 0, rd_dly = 0, wr_dly = 0;
  int dsc_cnt = 0, rd_cnt = 0, wr_cnt = 0;

  bit [31:0] dmem [bit [31:0]];
  logic [31:0] exp_rd[$], exp_wa[$], exp_wd[$], exp_dsc[$];
  logic [1:0]  exp_sz[$];
  byte         exp_evt[$];

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (dmem.exists(a)) return dmem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, expv, $time);
    end
  endtask

  // behavioural reference: walk the chain and queue every expected event
  task automatic predict(input logic [31:0] dv, input logic [31:0] mm, input logic [13:0] sz,
                         input logic [31:0] nx, input logic [1:0] md, input bit dr);
    logic [31:0] d, m, n;
    logic [13:0] s;
    bit go;
    d = dv; m = mm; s = sz; n = nx; go = 1;
    while (go) begin
      int wc, cnt, step, lim;
      wc = int'(s[13:12]); cnt = int'(s[11:0]);
      case (wc)
        3: begin step = 1; lim = 1023; end
        2: begin step = 2; lim = 1023; end
        0: begin step = 4; lim = 2047; end
        default: begin step = 0; lim = 0; end
      endcase
      if (step == 0 || cnt > lim) begin
        exp_evt.push_back("E");
        go = 0;
      end else begin
        for (int i = 0; i < cnt; i++) begin
          logic [31:0] src, dst;
          src = dr ? m : d;
          dst = dr ? d : m;
          exp_rd.push_back(src);
          exp_sz.push_back(step == 1 ? 2'd0 : (step == 2 ? 2'd1 : 2'd2));
          exp_wa.push_back(dst);
          exp_wd.push_back(src ^ KEY);
          m = m + step;
        end
        if (n[0]) exp_evt.push_back("I");
        if (md == 2'd1 && n[1]) begin
          logic [31:0] b;
          b = {n[31:2], 2'b00};
          for (int k = 0; k < 4; k++) exp_dsc.push_back(b + 4*k);
          d = rdm(b); m = rdm(b + 4); s = rdm(b + 8) & 32'h3FFF; n = rdm(b + 12);
        end else go = 0;
      end
    end
  endtask

  // responders: one-cycle acknowledge after a programmable delay
  always @(negedge clk) begin
    if (dsc_ack_i) dsc_ack_i = 1'b0;
    else if (rst_n && dsc_req_o) begin
      if (dsc_cnt >= dsc_dly) begin dsc_ack_i = 1'b1; dsc_data_i = rdm(dsc_addr_o); dsc_cnt = 0; end
      else dsc_cnt++;
    end
    if (rd_ack_i) rd_ack_i = 1'b0;
    else if (rst_n && rd_req_o) begin
      if (rd_cnt >= rd_dly) begin rd_ack_i = 1'b1; rd_data_i = rd_addr_o ^ KEY; rd_cnt = 0; end
      else rd_cnt++;
    end
    if (wr_ack_i) wr_ack_i = 1'b0;
    else if (rst_n && wr_req_o) begin
      if (wr_cnt >= wr_dly) begin wr_ack_i = 1'b1; wr_cnt = 0; end
      else wr_cnt++;
    end
  end

  // per-clock comparison against the reference queues
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      if (dsc_req_o && dsc_ack_i) begin
        n_dsc++;
        if (exp_dsc.size() == 0) chk(0, "R5 unexpected descriptor read", dsc_addr_o, 0);
        else begin
          logic [31:0] e;
          e = exp_dsc.pop_front();
          chk(dsc_addr_o == e, "R5 descriptor address", dsc_addr_o, e);
          chk(state_o == 2'd1, "R8 fetch state", 32'(state_o), 1);
        end
      end
      if (rd_req_o && rd_ack_i) begin
        n_rd++;
        if (exp_rd.size() == 0) chk(0, "R3 unexpected read", rd_addr_o, 0);
        else begin
          logic [31:0] e;
          logic [1:0] z;
          e = exp_rd.pop_front();
          z = exp_sz.pop_front();
          chk(rd_addr_o == e, "R3 read address", rd_addr_o, e);
          chk(elem_sz_o == z, "R1 element size", 32'(elem_sz_o), 32'(z));
          chk(state_o == 2'd3, "R8 access state", 32'(state_o), 3);
        end
      end
      if (wr_req_o && wr_ack_i) begin
        n_wr++;
        if (exp_wa.size() == 0) chk(0, "R3 unexpected write", wr_addr_o, 0);
        else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(wr_addr_o == ea, "R1 write address", wr_addr_o, ea);
          chk(wr_data_o == ed, "R3 write data", wr_data_o, ed);
        end
      end
      if (irq_o) begin
        n_irq++;
        if (exp_evt.size() == 0) chk(0, "R6 unexpected irq", 1, 0);
        else begin
          byte ev;
          ev = exp_evt.pop_front();
          chk(ev == "I", "R6 irq in order", 32'(ev), 32'("I"));
        end
      end
      if (err_o) begin
        if (exp_evt.size() == 0) chk(0, "R2 unexpected error", 1, 0);
        else begin
          byte ev;
          ev = exp_evt.pop_front();
          chk(ev == "E", "R2 error in order", 32'(ev), 32'("E"));
        end
      end
    end
  end

  task automatic go_start(input logic [31:0] dv, input logic [31:0] mm, input logic [13:0] sz,
                          input logic [31:0] nx, input logic [1:0] md, input bit dr);
    predict(dv, mm, sz, nx, md, dr);
    @(negedge clk);
    cfg_dev_i = dv; cfg_mem_i = mm; cfg_size_i = sz; cfg_next_i = nx;
    mode_i = md; dir_i = dr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(state_o == 2'd2, "R8 check state after start", 32'(state_o), 2);
  endtask

  task automatic wait_done(input string req);
    int idle;
    idle = 0;
    for (int c = 0; c < 20000 && idle < 4; c++) begin
      @(negedge clk);
      if (state_o == 2'd0 && exp_rd.size() == 0 && exp_dsc.size() == 0 && exp_evt.size() == 0)
        idle++;
      else idle = 0;
    end
    chk(exp_rd.size() == 0 && exp_wa.size() == 0, req, 32'(exp_rd.size()), 0);
    chk(exp_dsc.size() == 0 && exp_evt.size() == 0, req, 32'(exp_dsc.size() + exp_evt.size()), 0);
    chk(state_o == 2'd0, "R8 idle after chain", 32'(state_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base_wr, base_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state_o == 2'd0 && !irq_o && !err_o, "R8 reset state", 32'(state_o), 0);
    chk(!rd_req_o && !wr_req_o && !dsc_req_o, "R8 no request after reset", 32'(rd_req_o), 0);

    // one-shot, 4-byte, memory to device, interrupt on last
    go_start(32'h4000_0010, 32'h0000_8000, 14'h0003, 32'h0000_0001, 2'd2, 1'b1);
    wait_done("R1 R3 R6 one-shot 4B");

    // one-shot 1-byte device to memory, link code 3 must not be followed
    rd_dly = 2; wr_dly = 1;
    dmem[32'h0000_1000] = 32'h1;
    go_start(32'h4000_0020, 32'h0000_9001, 14'h3002, 32'h0000_1003, 2'd2, 1'b0);
    wait_done("R4 one-shot ignores link");
    chk(n_dsc == 0, "R4 no descriptor fetch", n_dsc, 0);

    // scatter-gather chain: 2B link+irq -> 4B link -> zero-count last+irq
    dsc_dly = 1; rd_dly = 0; wr_dly = 0;
    dmem[32'h0000_2000] = 32'h4000_0030; dmem[32'h0000_2004] = 32'h0000_A000;
    dmem[32'h0000_2008] = 32'h0000_0002; dmem[32'h0000_200C] = 32'h0000_3002;
    dmem[32'h0000_3000] = 32'h4000_0040; dmem[32'h0000_3004] = 32'h0000_B000;
    dmem[32'h0000_3008] = 32'h0000_0000; dmem[32'h0000_300C] = 32'h0000_0001;
    base_irq = n_irq;
    go_start(32'h4000_0050, 32'h0000_C002, 14'h2002, 32'h0000_2003, 2'd1, 1'b1);
    wait_done("R5 R10 chain");
    chk(n_irq - base_irq == 2, "R6 R10 irq count for chain", n_irq - base_irq, 2);

    // illegal width code 1
    go_start(32'h4000_0060, 32'h0000_D000, 14'h1004, 32'h0000_0001, 2'd2, 1'b1);
    wait_done("R2 width code 1 rejected");
    // count over 2-byte limit
    go_start(32'h4000_0060, 32'h0000_D000, 14'h2400, 32'h0000_0001, 2'd2, 1'b1);
    wait_done("R2 count over limit rejected");
    // count 0x800 at 4-byte width
    go_start(32'h4000_0060, 32'h0000_D000, 14'h0800, 32'h0000_0001, 2'd2, 1'b0);
    wait_done("R2 4B count over limit rejected");
    // 1-byte count exactly at limit is legal
    go_start(32'h4000_0070, 32'h0001_0000, 14'h33FF, 32'h0000_0001, 2'd2, 1'b1);
    wait_done("R2 1B count at limit accepted");

    // linked descriptor that is bad: irq then error
    dmem[32'h0000_5000] = 32'h4000_0080; dmem[32'h0000_5004] = 32'h0000_E000;
    dmem[32'h0000_5008] = 32'h0000_1001; dmem[32'h0000_500C] = 32'h0000_0001;
    go_start(32'h4000_0090, 32'h0000_F000, 14'h0001, 32'h0000_5003, 2'd1, 1'b0);
    wait_done("R2 R5 bad fetched descriptor");

    // start while busy is ignored
    rd_dly = 1;
    go_start(32'h4000_00A0, 32'h0002_0000, 14'h0006, 32'h0000_0000, 2'd2, 1'b0);
    wait (state_o == 2'd3);
    @(negedge clk);
    cfg_dev_i = 32'hDEAD_0000; cfg_mem_i = 32'hBEEF_0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(state_o != 2'd2, "R9 start ignored while busy", 32'(state_o), 3);
    wait_done("R9 transfer unchanged by start");

    // start with mode disabled is ignored
    @(negedge clk);
    mode_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      chk(state_o == 2'd0 && !rd_req_o && !dsc_req_o, "R9 start ignored when disabled", 32'(state_o), 0);
      @(negedge clk);
    end

    // abort after the first element boundary: exactly two elements move
    rd_dly = 0;
    base_wr = n_wr; base_irq = n_irq;
    go_start(32'h4000_00B0, 32'h0003_0000, 14'h0005, 32'h0000_0001, 2'd2, 1'b1);
    wait (n_wr == base_wr + 1);
    @(negedge clk);
    mode_i = 2'd0;
    repeat (30) @(negedge clk);
    chk(n_wr - base_wr == 2, "R7 elements before abort", n_wr - base_wr, 2);
    chk(n_irq == base_irq, "R7 no irq on abort", n_irq - base_irq, 0);
    chk(state_o == 2'd0 && !rd_req_o, "R7 idle after abort", 32'(state_o), 0);
    exp_rd.delete(); exp_wa.delete(); exp_wd.delete(); exp_sz.delete(); exp_evt.delete();

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule